// File: doc/BRIEF.md
# Tick-Based Watchdog Timer

This block is a watchdog peripheral behind a simple 32-bit word-access register bus. A programmable prescaler turns the input clock into a slow periodic tick, typically one millisecond. A tick counter advances while the watchdog runs and raises a system reset request once it reaches the programmed timeout. Software keeps the system alive by writing to a restart register before that happens.

Software can also demand a reset at once through a control bit, whatever the count and the run state. Every reset request takes the form of a fixed-length pulse. A separate output carries the software's choice of which reset domain an expiry should hit, for the system reset controller to use.

Top module: `tick_watchdog`

## Requirements
- R1: After bus reset all three registers read 0, the watchdog is stopped and the reset output is low.
- R2: Register map (byte address, bits [1:0] ignored): control at 0x0, timeout at 0x8, restart at 0xC. Control stores divide [17:0], run [18], domain select [21], clock gate [24] and divider enable [25], and reads back only those bits. Timeout keeps bits [15:0] only, so upper bits read 0 and have no effect on expiry. Restart and the unused word 0x4 read as 0.
- R3: With bits 24 and 25 set and a divide value N ≥ 1, one tick occurs every N clocks. A write that turns on the clocks and run together, with the tick count at zero and timeout T, raises the reset output exactly N·T clocks after that write's edge.
- R4: No tick and no expiry happen while bit 24 is clear, while bit 25 is clear, or while the divide value is 0.
- R5: Each reset request produces a pulse that is high for exactly 16 clocks. Requests that arrive while a pulse is high are ignored.
- R6: A write of any data to the restart register returns the tick count to zero. With divide 1, the next expiry comes T clocks after that write's edge.
- R7: Clearing bit 18 freezes the tick count and prevents expiry. Setting it again resumes counting from the frozen value.
- R8: A timeout of 0 never expires.
- R9: Writing control with bit 26 set starts a reset pulse on the clock after the write, even with the watchdog stopped. Bit 26 always reads as 0.
- R10: The domain-select output always equals stored control bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst_o | output | 1 | Reset request pulse |
| wdt_dom_o | output | 1 | Domain-select level for the reset controller |

## Verification
The bench sweeps the divide and timeout values over a small grid and checks each expiry cycle against N·T. A prescaler with an off-by-one period, or a comparison done before the increment, would fail every point of that grid. It also measures the pulse width after each trigger, including triggers that fall inside a running pulse, which catches a generator that stretches or restarts its pulse. Further checks cover the freeze-and-resume count, a zero timeout, a zero divide, each gate bit on its own, timeout bits above 15, and a forced reset while stopped. A design that wrapped at the wrong width, let a gate through or kept the force bit stored would go wrong on those.

// File: rtl/wdt_pkg.sv
// Shared constants for the watchdog: the control bit layout that software
// depends on, and the word indices of the three registers.
package wdt_pkg;
    localparam int DIV_W       = 18;
    localparam int BIT_RUN     = 18;
    localparam int BIT_DOMAIN  = 21;
    localparam int BIT_CLK_ON  = 24;
    localparam int BIT_DIV_ON  = 25;
    localparam int BIT_FORCE   = 26;

    localparam logic [1:0] IDX_CTRL    = 2'd0;
    localparam logic [1:0] IDX_TIMEOUT = 2'd2;
    localparam logic [1:0] IDX_RESTART = 2'd3;

    typedef struct packed {
        logic             div_on;
        logic             clk_on;
        logic             domain;
        logic             run;
        logic [DIV_W-1:0] divide;
    } ctrl_t;
endpackage

// File: rtl/wdt_regfile.sv
// Register file of the watchdog. Decodes word index addr[3:2], stores the
// control fields and the timeout, and turns writes to the restart register
// and of the force bit into one-cycle strobes. Assumes one write per cycle
// and reads without side effects.
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [TMO_W-1:0]  limit,
    output logic              restart,
    output logic              force_now
);
    localparam int PAD_W = DATA_W - TMO_W;

    logic [1:0] idx;
    assign idx = addr[3:2];

    // Strobes derived straight from the current bus write
    assign restart   = wr_en && (idx == IDX_RESTART);
    assign force_now = wr_en && (idx == IDX_CTRL) && wdata[BIT_FORCE];

    // Stored control fields and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            limit <= '0;
        end else if (wr_en) begin
            if (idx == IDX_CTRL) begin
                ctrl.divide <= wdata[DIV_W-1:0];
                ctrl.run    <= wdata[BIT_RUN];
                ctrl.domain <= wdata[BIT_DOMAIN];
                ctrl.clk_on <= wdata[BIT_CLK_ON];
                ctrl.div_on <= wdata[BIT_DIV_ON];
            end else if (idx == IDX_TIMEOUT) begin
                limit <= wdata[TMO_W-1:0];
            end
        end
    end

    // Read multiplexer: stored bits only, everything else zero
    always_comb begin
        rdata = '0;
        case (idx)
            IDX_CTRL: begin
                rdata[DIV_W-1:0]  = ctrl.divide;
                rdata[BIT_RUN]    = ctrl.run;
                rdata[BIT_DOMAIN] = ctrl.domain;
                rdata[BIT_CLK_ON] = ctrl.clk_on;
                rdata[BIT_DIV_ON] = ctrl.div_on;
            end
            IDX_TIMEOUT: rdata = {{PAD_W{1'b0}}, limit};
            default:     rdata = '0;
        endcase
    end

    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_CTRL) |=> (ctrl.run == $past(wdata[BIT_RUN]))); // R2
    AST_LIMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == IDX_TIMEOUT) |=> $stable(limit)); // R2
endmodule

// File: rtl/wdt_prescaler.sv
// Prescaler: divides the clock into a one-cycle tick every DIVIDE clocks.
// Runs only with both gate bits set and a non-zero divide value, and holds
// its phase at zero otherwise. A divide value lowered below the current
// phase wraps on the next clock.
module wdt_prescaler #(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_on,
    input  logic             div_on,
    input  logic [DIV_W-1:0] divide,
    output logic             tick
);
    logic [DIV_W-1:0] phase;
    logic             active;
    logic             last;

    assign active = clk_on && div_on && (divide != '0);
    assign last   = (phase >= divide - 1'b1);
    assign tick   = active && last;

    // Phase counter, cleared while gated
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (!active) phase <= '0;
        else if (last)    phase <= '0;
        else              phase <= phase + 1'b1;
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $stable(divide)) |-> (phase < divide)); // R3
    AST_GATED_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase == '0)); // R4
endmodule

// File: rtl/wdt_tick_counter.sv
// Tick counter: advances on each tick while running and flags expiry when
// the incremented value equals the timeout, clearing itself at that point.
// A restart strobe has priority and clears the count without expiry. The
// compare is one bit wider than the count, so a timeout of zero never hits.
module wdt_tick_counter #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] count;
    logic [TMO_W:0]   bumped;
    logic             step;
    logic             hit;

    assign step   = run && tick;
    assign bumped = {1'b0, count} + 1'b1;
    assign hit    = step && (bumped == {1'b0, limit});
    assign expire = hit && !restart;

    // Count update: restart, then expiry clear, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else if (hit)     count <= '0;
        else if (step)    count <= bumped[TMO_W-1:0];
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0)); // R6
    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(count)); // R7
    AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !expire); // R8
endmodule

// File: rtl/wdt_pulse_gen.sv
// Reset pulse generator: a request while idle starts a pulse of exactly
// PULSE_LEN clocks from the next clock on; requests during a pulse are
// dropped. Assumes PULSE_LEN is at least 2.
module wdt_pulse_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_LEN);

    logic          active;
    logic [CW-1:0] left;

    assign pulse = active;

    // Pulse state and remaining length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
        end else if (!active) begin
            if (trigger) begin
                active <= 1'b1;
                left   <= CW'(PULSE_LEN - 1);
            end
        end else if (left == '0) begin
            active <= 1'b0;
        end else begin
            left <= left - 1'b1;
        end
    end

    AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && !pulse) |=> pulse); // R5
    AST_HOLD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && left != '0) |=> pulse); // R5
    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && left == '0) |=> !pulse); // R5
endmodule

// File: rtl/tick_watchdog.sv
// Watchdog top: register file, prescaler, tick counter and pulse generator.
// Expiry and the software force bit share one pulse generator. Assumes a
// single clock domain and a synchronous active-low bus reset.
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int TMO_W     = 16,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_o,
    output logic              wdt_dom_o
);
    ctrl_t            ctrl;
    logic [TMO_W-1:0] limit;
    logic             restart;
    logic             force_now;
    logic             tick;
    logic             expire;
    logic             trigger;

    wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl), .limit(limit),
        .restart(restart), .force_now(force_now)
    );

    wdt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clk_on(ctrl.clk_on), .div_on(ctrl.div_on),
        .divide(ctrl.divide), .tick(tick)
    );

    wdt_tick_counter #(.TMO_W(TMO_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick),
        .restart(restart), .limit(limit), .expire(expire)
    );

    assign trigger = expire || force_now;

    wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .pulse(wdt_rst_o)
    );

    assign wdt_dom_o = ctrl.domain;

    AST_FORCE_REACHES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        force_now |=> wdt_rst_o); // R9
    AST_NO_EXPIRY_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !expire); // R7
endmodule

// File: tb/tick_watchdog_test.sv
`timescale 1ns/1ps
module tick_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;
    logic        wdt_dom_o;

    int errors = 0;
    int checks = 0;
    int run_len = 0;
    int last_run = 0;
    bit finished = 1'b0;

    localparam logic [31:0] CLKS = 32'h0300_0000;
    localparam logic [31:0] RUN  = 32'h0004_0000;

    tick_watchdog uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .wdt_dom_o(wdt_dom_o)
    );

    always #2.5 clk = ~clk;

    // Length of the most recent completed high run of the reset output
    always @(negedge clk) begin
        if (wdt_rst_o) run_len = run_len + 1;
        else if (run_len != 0) begin last_run = run_len; run_len = 0; end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Edges from the last write until the reset output is seen high
    task automatic measure(output int n);
        n = 0;
        while (!wdt_rst_o && n < 200) begin
            @(posedge clk); n++; @(negedge clk);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Watch for a reset over k cycles; returns 1 if none seen
    task automatic quiet(input int k, output bit ok);
        ok = 1'b1;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (wdt_rst_o) ok = 1'b0;
        end
    endtask

    task automatic clean();
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        idle(20);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        bit ok;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check(v == 0, "R1 ctrl", v, 0);
        rd(4'h8, v); check(v == 0, "R1 timeout", v, 0);
        rd(4'hC, v); check(v == 0, "R1 restart", v, 0);
        check(!wdt_rst_o, "R1 rst_o", wdt_rst_o, 0);

        // R2 readback and masking
        wr(4'h8, 32'hFFFF_ABCD);
        rd(4'h8, v); check(v == 32'h0000_ABCD, "R2 timeout mask", v, 32'h0000_ABCD);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check(v == 32'h0327_FFFF, "R2 ctrl fields", v, 32'h0327_FFFF);
        rd(4'hC, v); check(v == 0, "R2 restart reads zero", v, 0);
        rd(4'h4, v); check(v == 0, "R2 unused word", v, 0);
        clean();
        idle(20);

        // R2 timeout bits above 15 do not affect expiry
        wr(4'h8, 32'h0001_0002);
        wr(4'h0, CLKS | RUN | 32'd1);
        measure(n); check(n == 2, "R2 upper timeout bits", n, 2);
        clean();

        // R3/R5 sweep of divide and timeout
        for (int d = 1; d <= 4; d++) begin
            for (int t = 1; t <= 3; t++) begin
                wr(4'h8, t);
                wr(4'h0, CLKS | RUN | d);
                measure(n);
                check(n == d * t, "R3 expiry cycle", n, d * t);
                wr(4'h0, CLKS | d);
                idle(20);
                check(last_run == 16, "R5 pulse width", last_run, 16);
                clean();
            end
        end

        // R5 repeated expiry inside a pulse is dropped: divide 2, timeout 4
        wr(4'h8, 32'd4);
        wr(4'h0, CLKS | RUN | 32'd2);
        measure(n);
        idle(14);
        wr(4'h0, CLKS);
        idle(20);
        check(last_run == 16, "R5 retrigger ignored", last_run, 16);
        clean();

        // R4 gates and zero divide
        wr(4'h8, 32'd1);
        wr(4'h0, 32'h0100_0000 | RUN | 32'd1);
        quiet(30, ok); check(ok, "R4 divider enable clear", 0, 0);
        wr(4'h0, 32'h0200_0000 | RUN | 32'd1);
        quiet(30, ok); check(ok, "R4 clock gate clear", 0, 0);
        wr(4'h0, CLKS | RUN);
        quiet(30, ok); check(ok, "R4 divide zero", 0, 0);
        clean();

        // R6 restart keeps it alive, then expiry T after last restart
        wr(4'h8, 32'd5);
        wr(4'h0, CLKS | RUN | 32'd1);
        ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            idle(3);
            if (wdt_rst_o) ok = 1'b0;
            wr(4'hC, 32'hDEAD_0000 + k);
        end
        check(ok, "R6 restart holds off reset", 0, 0);
        measure(n); check(n == 5, "R6 expiry after restart", n, 5);
        clean();

        // R7 freeze and resume
        wr(4'h8, 32'd10);
        wr(4'h0, CLKS | RUN | 32'd1);
        idle(3);
        wr(4'h0, CLKS | 32'd1);
        quiet(20, ok); check(ok, "R7 frozen no expiry", 0, 0);
        wr(4'h0, CLKS | RUN | 32'd1);
        measure(n); check(n == 6, "R7 resume from frozen count", n, 6);
        clean();

        // R8 zero timeout
        wr(4'h8, 32'd0);
        wr(4'h0, CLKS | RUN | 32'd1);
        quiet(100, ok); check(ok, "R8 zero timeout", 0, 0);
        clean();

        // R9 force while stopped, R10 domain select
        wr(4'h0, 32'h0420_0000);
        check(wdt_rst_o, "R9 force immediate", wdt_rst_o, 1);
        rd(4'h0, v); check(v == 32'h0020_0000, "R9 force bit reads zero", v, 32'h0020_0000);
        check(wdt_dom_o, "R10 domain high", wdt_dom_o, 1);
        idle(20);
        check(last_run == 16, "R9 forced pulse width", last_run, 16);
        wr(4'h0, 32'h0);
        check(!wdt_dom_o, "R10 domain low", wdt_dom_o, 0);

        finished = 1'b1;
        summary();
    end
endmodule